// File: doc/BRIEF.md
# Transceiver Power Mode Controller

This block sequences the power modes of a single-wire bus transceiver that has its own supply regulator. Digital flags from analog comparators report the supply and regulator health. Further inputs give the host's chip-select/local-wake line, the transmitter-enable line, the transmit data level, a bus wake pulse and an internal fault flag. From these, a five-state machine decides which parts of the transceiver are powered. The states are power-on reset, ready, operation, transmitter-off and power-down.

All inputs pass through a synchronizer first. The controller then drives six outputs:
- the regulator enable,
- a low-power hint for the regulator,
- the receiver and transmitter enables,
- the bus pull-up connect,
- an active-low reset for the host.

A short-circuit retry timer turns the regulator off when its output collapses. The timer keeps it off for a fixed number of cycles, then lets it try again.

Top module: `xcvr_pwr_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the controller is in power-on reset: every output, including `rst_out_n_o`, is low.
- R2: Power-on reset moves to ready when `sup_on_i` is high. A high `sup_off_i` sends every state back to power-on reset, and this takes priority over every other transition.
- R3: In ready, `reg_en_o`, `rx_en_o` and `reg_lowpwr_o` are high and `tx_en_o` is low. Ready moves to operation when chip select, the effective enable and transmit data are all high and the regulator is good.
- R4: The effective enable is `txen_i` high and `int_fault_i` low. Ready moves to transmitter-off when chip select is high and the effective enable is low. Transmitter-off moves to operation when chip select, the effective enable and transmit data are high, whatever the regulator health.
- R5: Operation moves to power-down on a falling edge of chip select. Operation moves to transmitter-off on a falling edge of the effective enable while chip select stays high. Transmitter-off moves to power-down while chip select is low.
- R6: In power-down, regulator, receiver, transmitter, pull-up and low-power hint are all off. Power-down moves to ready when chip select is high or when a bus wake pulse arrives.
- R7: `bus_pullup_o` is high only in operation. `reg_lowpwr_o` is high only in ready and transmitter-off.
- R8: `tx_en_o` is high only in operation, and only while the regulator is good, no retry is pending and `int_fault_i` is low.
- R9: `vreg_short_i` seen while the regulator is enabled turns the regulator off for `RETRY_CYCLES` cycles, then on for one cycle of re-check. The retry starts again if the short is still present. While a retry is pending, `vreg_ok_i` is treated as low.
- R10: `rst_out_n_o` is high only outside power-on reset, with `vreg_ok_i` high and no retry pending.
- R11: Each input acts after `SYNC_STAGES` clock edges. Combinational gating (R8, R10) shows at that point. A state change shows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_on_i | input | 1 | Supply above turn-on threshold |
| sup_off_i | input | 1 | Supply below turn-off threshold |
| vreg_ok_i | input | 1 | Regulator output above 80% of nominal |
| vreg_short_i | input | 1 | Regulator output below shutdown level |
| csel_wake_i | input | 1 | Chip select / local wake level |
| txen_i | input | 1 | Transmitter enable level |
| txd_i | input | 1 | Transmit data level |
| bus_wake_i | input | 1 | Bus wake detected pulse |
| int_fault_i | input | 1 | Internal fault (pulls enable low) |
| reg_en_o | output | 1 | Regulator enable |
| reg_lowpwr_o | output | 1 | Regulator reduced-power hint |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| bus_pullup_o | output | 1 | Bus pull-up connect |
| rst_out_n_o | output | 1 | Active-low reset to host |

## Verification
A wrong state shows at the ports one edge after the transition that caused it. For example, a missing move to operation keeps `bus_pullup_o` low, and a missed brown-out keeps `rx_en_o` high. Ready and transmitter-off drive the same outputs, so confusing them shows up only at the next input change, through which transition follows. A retry counter that is off by one shifts the single re-enable cycle of `reg_en_o` by one clock. This is visible in the same cycle, because the reference model is compared on every clock.

// File: rtl/xcvr_pwr_pkg.sv
package xcvr_pwr_pkg;

   typedef enum logic [2:0] {
      PM_RST   = 3'd0,
      PM_RDY   = 3'd1,
      PM_OPER  = 3'd2,
      PM_TXOFF = 3'd3,
      PM_PDN   = 3'd4
   } pm_state_e;

   typedef struct packed {
      logic sup_on;
      logic sup_off;
      logic vgood;
      logic vshort;
      logic csel;
      logic txen;
      logic txd;
      logic wake;
      logic fault;
   } pm_in_t;

   localparam int PM_IN_W = $bits(pm_in_t);

   function automatic logic pm_powered(pm_state_e s);
      return (s == PM_RDY) || (s == PM_OPER) || (s == PM_TXOFF);
   endfunction

endpackage

// File: rtl/xcvr_pwr_sync.sv
module xcvr_pwr_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("xcvr_pwr_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("xcvr_pwr_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/xcvr_pwr_retry.sv
module xcvr_pwr_retry #(
   parameter int RETRY_CYCLES = 300000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic powered,
   input  logic short_s,
   output logic pending
);
   localparam int CNT_W = (RETRY_CYCLES > 1) ? $clog2(RETRY_CYCLES) : 1;
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(RETRY_CYCLES - 1);

   generate
      if (RETRY_CYCLES < 2) begin : g_bad_retry
         $error("xcvr_pwr_retry: RETRY_CYCLES must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         cnt     <= '0;
      end else if (!powered) begin
         pending <= 1'b0;
         cnt     <= '0;
      end else if (pending) begin
         if (cnt == '0) begin
            pending <= 1'b0;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end else if (short_s) begin
         pending <= 1'b1;
         cnt     <= RELOAD;
      end
   end
endmodule

// File: rtl/xcvr_pwr_fsm.sv
module xcvr_pwr_fsm
   import xcvr_pwr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      on_s,
   input  logic      off_s,
   input  logic      vok,
   input  logic      cs_s,
   input  logic      en_s,
   input  logic      txd_s,
   input  logic      wake_s,
   output pm_state_e state
);
   pm_state_e nxt;
   logic      cs_q;
   logic      en_q;
   logic      cs_fall;
   logic      en_fall;
   logic      go_oper;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q <= 1'b0;
         en_q <= 1'b0;
      end else begin
         cs_q <= cs_s;
         en_q <= en_s;
      end
   end

   assign cs_fall = cs_q & ~cs_s;
   assign en_fall = en_q & ~en_s;
   assign go_oper = cs_s & en_s & txd_s;

   always_comb begin
      nxt = state;
      if (off_s) begin
         nxt = PM_RST;
      end else begin
         unique case (state)
            PM_RST: begin
               if (on_s) nxt = PM_RDY;
            end
            PM_RDY: begin
               if (go_oper && vok)        nxt = PM_OPER;
               else if (cs_s && !en_s)    nxt = PM_TXOFF;
            end
            PM_OPER: begin
               if (cs_fall)               nxt = PM_PDN;
               else if (en_fall && cs_s)  nxt = PM_TXOFF;
            end
            PM_TXOFF: begin
               if (!cs_s)                 nxt = PM_PDN;
               else if (go_oper)          nxt = PM_OPER;
            end
            PM_PDN: begin
               if (cs_s || wake_s)        nxt = PM_RDY;
            end
            default: nxt = PM_RST;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PM_RST;
      else        state <= nxt;
   end
endmodule

// File: rtl/xcvr_pwr_outdec.sv
module xcvr_pwr_outdec
   import xcvr_pwr_pkg::*;
(
   input  pm_state_e state,
   input  logic      pend,
   input  logic      good_s,
   input  logic      fault_s,
   output logic      reg_en,
   output logic      reg_lowpwr,
   output logic      rx_en,
   output logic      tx_en,
   output logic      bus_pullup,
   output logic      rst_out_n
);
   logic pwr;
   logic healthy;

   assign pwr        = pm_powered(state);
   assign healthy    = good_s & ~pend;
   assign reg_en     = pwr & ~pend;
   assign reg_lowpwr = (state == PM_RDY) | (state == PM_TXOFF);
   assign rx_en      = pwr;
   assign bus_pullup = (state == PM_OPER);
   assign tx_en      = (state == PM_OPER) & healthy & ~fault_s;
   assign rst_out_n  = (state != PM_RST) & healthy;
endmodule

// File: rtl/xcvr_pwr_ctrl.sv
module xcvr_pwr_ctrl
   import xcvr_pwr_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int RETRY_CYCLES = 300000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_on_i,
   input  logic sup_off_i,
   input  logic vreg_ok_i,
   input  logic vreg_short_i,
   input  logic csel_wake_i,
   input  logic txen_i,
   input  logic txd_i,
   input  logic bus_wake_i,
   input  logic int_fault_i,
   output logic reg_en_o,
   output logic reg_lowpwr_o,
   output logic rx_en_o,
   output logic tx_en_o,
   output logic bus_pullup_o,
   output logic rst_out_n_o
);
   pm_in_t    raw;
   pm_in_t    syn;
   pm_state_e state;
   logic      pend;
   logic      off_s;
   logic      good_s;
   logic      en_eff;
   logic      vok;

   assign raw = '{sup_on:  sup_on_i,
                  sup_off: sup_off_i,
                  vgood:   vreg_ok_i,
                  vshort:  vreg_short_i,
                  csel:    csel_wake_i,
                  txen:    txen_i,
                  txd:     txd_i,
                  wake:    bus_wake_i,
                  fault:   int_fault_i};

   xcvr_pwr_sync #(
      .W      (PM_IN_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (syn)
   );

   assign off_s  = syn.sup_off;
   assign good_s = syn.vgood;
   assign en_eff = syn.txen & ~syn.fault;
   assign vok    = good_s & ~pend;

   xcvr_pwr_retry #(
      .RETRY_CYCLES (RETRY_CYCLES)
   ) u_retry (
      .clk     (clk),
      .rst_n   (rst_n),
      .powered (pm_powered(state)),
      .short_s (syn.vshort),
      .pending (pend)
   );

   xcvr_pwr_fsm u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .on_s   (syn.sup_on),
      .off_s  (off_s),
      .vok    (vok),
      .cs_s   (syn.csel),
      .en_s   (en_eff),
      .txd_s  (syn.txd),
      .wake_s (syn.wake),
      .state  (state)
   );

   xcvr_pwr_outdec u_out (
      .state      (state),
      .pend       (pend),
      .good_s     (good_s),
      .fault_s    (syn.fault),
      .reg_en     (reg_en_o),
      .reg_lowpwr (reg_lowpwr_o),
      .rx_en      (rx_en_o),
      .tx_en      (tx_en_o),
      .bus_pullup (bus_pullup_o),
      .rst_out_n  (rst_out_n_o)
   );
endmodule

// File: rtl/xcvr_pwr_ctrl_chk.sv
module xcvr_pwr_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic reg_en,
   input logic reg_lowpwr,
   input logic rx_en,
   input logic tx_en,
   input logic bus_pullup,
   input logic rst_out_n,
   input logic brownout_s,
   input logic good_s,
   input logic retry_pend
);
   a_r7_pullup_needs_rx: assert property (@(posedge clk) disable iff (!rst_n)
      bus_pullup |-> rx_en);

   a_r7_lowpwr_not_oper: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_lowpwr && bus_pullup));

   a_r8_tx_needs_oper: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |-> (bus_pullup && reg_en && rst_out_n));

   a_r2_brownout_reset: assert property (@(posedge clk) disable iff (!rst_n)
      brownout_s |=> (!rx_en && !reg_en && !rst_out_n && !tx_en));

   a_r9_reg_off_pending: assert property (@(posedge clk) disable iff (!rst_n)
      retry_pend |-> (!reg_en && !tx_en && !rst_out_n));

   a_r10_rst_follows_good: assert property (@(posedge clk) disable iff (!rst_n)
      !good_s |-> (!rst_out_n && !tx_en));

   a_r6_unpowered_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |-> (!reg_en && !tx_en && !bus_pullup && !reg_lowpwr));
endmodule

bind xcvr_pwr_ctrl xcvr_pwr_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_en     (reg_en_o),
   .reg_lowpwr (reg_lowpwr_o),
   .rx_en      (rx_en_o),
   .tx_en      (tx_en_o),
   .bus_pullup (bus_pullup_o),
   .rst_out_n  (rst_out_n_o),
   .brownout_s (off_s),
   .good_s     (good_s),
   .retry_pend (pend)
);

// File: tb/tb_xcvr_pwr_ctrl.sv
module tb_xcvr_pwr_ctrl;
   localparam int SYNC  = 2;
   localparam int RETRY = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sup_on = 0, sup_off = 0, vgood = 0, vshort = 0;
   logic csel = 0, txen = 1, txd = 1, wake = 0, fault = 0;
   logic reg_en, reg_lowpwr, rx_en, tx_en, bus_pullup, rst_out_n;

   always #5 clk = ~clk;

   xcvr_pwr_ctrl #(.SYNC_STAGES(SYNC), .RETRY_CYCLES(RETRY)) dut (
      .clk(clk), .rst_n(rst_n),
      .sup_on_i(sup_on), .sup_off_i(sup_off), .vreg_ok_i(vgood),
      .vreg_short_i(vshort), .csel_wake_i(csel), .txen_i(txen),
      .txd_i(txd), .bus_wake_i(wake), .int_fault_i(fault),
      .reg_en_o(reg_en), .reg_lowpwr_o(reg_lowpwr), .rx_en_o(rx_en),
      .tx_en_o(tx_en), .bus_pullup_o(bus_pullup), .rst_out_n_o(rst_out_n)
   );

   int    tests = 0;
   int    fails = 0;
   string cur_req = "R1";

   // reference model: 0 reset, 1 ready, 2 operation, 3 tx-off, 4 power-down
   int         m_state;
   bit         m_pend;
   int         m_left;
   bit         m_cs_q, m_en_q;
   logic [8:0] m_pipe [SYNC];

   function automatic logic [5:0] model_out();
      bit good = m_pipe[SYNC-1][6];
      bit flt  = m_pipe[SYNC-1][0];
      bit pwr  = (m_state >= 1 && m_state <= 3);
      bit ok   = good && !m_pend;
      return {pwr && !m_pend, (m_state == 1 || m_state == 3), pwr,
              (m_state == 2) && ok && !flt, (m_state == 2),
              (m_state != 0) && ok};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state = 0; m_pend = 0; m_left = 0; m_cs_q = 0; m_en_q = 0;
         for (int i = 0; i < SYNC; i++) m_pipe[i] = '0;
      end else begin
         logic [8:0] v = m_pipe[SYNC-1];
         bit on = v[8], off = v[7], good = v[6], sh = v[5], cs = v[4];
         bit en = v[3] && !v[0], d = v[2], wk = v[1];
         bit ok = good && !m_pend;
         int ns = m_state;
         if (off) ns = 0;
         else if (m_state == 0) begin if (on) ns = 1; end
         else if (m_state == 1) begin
            if (cs && en && d && ok) ns = 2;
            else if (cs && !en) ns = 3;
         end else if (m_state == 2) begin
            if (m_cs_q && !cs) ns = 4;
            else if (m_en_q && !en && cs) ns = 3;
         end else if (m_state == 3) begin
            if (!cs) ns = 4;
            else if (cs && en && d) ns = 2;
         end else begin
            if (cs || wk) ns = 1;
         end
         if (!(m_state >= 1 && m_state <= 3)) begin
            m_pend = 0; m_left = 0;
         end else if (m_pend) begin
            if (m_left == 0) m_pend = 0; else m_left--;
         end else if (sh) begin
            m_pend = 1; m_left = RETRY - 1;
         end
         m_cs_q = cs; m_en_q = en; m_state = ns;
         for (int i = SYNC - 1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
         m_pipe[0] = {sup_on, sup_off, vgood, vshort, csel, txen, txd, wake, fault};
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      logic [5:0] act = {reg_en, reg_lowpwr, rx_en, tx_en, bus_pullup, rst_out_n};
      logic [5:0] exp = model_out();
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s cycle compare at %0t: act=%b exp=%b", cur_req, $time, act, exp);
      end
   end

   task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s directed check: act=%b exp=%b", req, act, exp);
      end
   endtask

   task automatic wcyc(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [5:0] outs();
      return {reg_en, reg_lowpwr, rx_en, tx_en, bus_pullup, rst_out_n};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int highs;
      // R1: reset state
      cur_req = "R1";
      wcyc(3);
      chk("R1", outs(), 6'b000000);
      rst_n = 1'b1;
      wcyc(4);
      chk("R1", outs(), 6'b000000);

      // R2: supply rises -> ready
      cur_req = "R2";
      sup_on = 1; wcyc(5);
      chk("R2", outs(), 6'b111000);
      // R3: regulator good, data low keeps ready; then data high -> operation
      cur_req = "R3";
      vgood = 1; csel = 1; txd = 0; wcyc(6);
      chk("R3", outs(), 6'b111001);
      txd = 1; wcyc(5);
      chk("R3", outs(), 6'b101111);
      chk("R7", {5'b0, bus_pullup}, 6'b000001);

      // R8: internal fault drops transmitter, effective enable falls -> tx-off
      cur_req = "R8";
      fault = 1; wcyc(SYNC);
      @(negedge clk);
      chk("R8", {5'b0, tx_en}, 6'b0);
      wcyc(4);
      chk("R8", outs(), 6'b111001);
      fault = 0; wcyc(5);
      chk("R4", outs(), 6'b101111);

      // R5: enable falling -> tx-off, back, then chip select falling -> power-down
      cur_req = "R5";
      txen = 0; wcyc(5);
      chk("R5", outs(), 6'b111001);
      txen = 1; wcyc(5);
      chk("R5", outs(), 6'b101111);
      csel = 0; wcyc(5);
      chk("R5", {reg_en, rx_en, tx_en, bus_pullup, reg_lowpwr, 1'b0}, 6'b0);

      // R6: bus wake pulse -> ready; stays with chip select low
      cur_req = "R6";
      wake = 1; @(negedge clk); wake = 0; wcyc(8);
      chk("R6", outs(), 6'b111001);
      csel = 1; wcyc(5);
      chk("R6", outs(), 6'b101111);
      csel = 0; wcyc(5);
      chk("R6", outs(), 6'b000001);
      csel = 1; wcyc(8);
      chk("R6", outs(), 6'b101111);

      // R4: ready -> tx-off, then tx-off -> operation without a good regulator
      cur_req = "R4";
      csel = 0; wcyc(5);
      wake = 1; @(negedge clk); wake = 0; txen = 0; wcyc(6);
      csel = 1; wcyc(5);
      chk("R4", outs(), 6'b111001);
      cur_req = "R10";
      vgood = 0; wcyc(4);
      chk("R10", {5'b0, rst_out_n}, 6'b0);
      txen = 1; wcyc(5);
      chk("R4", outs(), 6'b101010);
      vgood = 1; wcyc(4);
      chk("R10", outs(), 6'b101111);

      // R9: short -> regulator off for RETRY cycles
      cur_req = "R9";
      vshort = 1; wcyc(5);
      chk("R9", {reg_en, 4'b0, rst_out_n}, 6'b0);
      vshort = 0; wcyc(RETRY + 4);
      chk("R9", outs(), 6'b101111);
      vshort = 1; wcyc(RETRY + 6);
      highs = 0;
      for (int i = 0; i < 3 * (RETRY + 1); i++) begin
         @(negedge clk);
         if (reg_en) highs++;
      end
      chk("R9", 6'(highs), 6'd3);
      vshort = 0; wcyc(RETRY + 4);

      // R9: good flag ignored while pending (ready does not move to operation)
      csel = 0; wcyc(5);
      wake = 1; @(negedge clk); wake = 0; wcyc(6);
      vshort = 1; wcyc(4); vshort = 0;
      csel = 1; wcyc(6);
      chk("R9", {5'b0, bus_pullup}, 6'b0);
      wcyc(RETRY);
      chk("R9", {5'b0, bus_pullup}, 6'b000001);

      // R2: brown-out from operation, then recovery
      cur_req = "R2";
      sup_off = 1; wcyc(5);
      chk("R2", outs(), 6'b000000);
      sup_off = 0; wcyc(5);
      chk("R11", outs(), 6'b101111);

      // R11: exact latency of a chip-select fall to the pull-up release
      cur_req = "R11";
      csel = 0;
      wcyc(SYNC);
      chk("R11", {5'b0, bus_pullup}, 6'b000001);
      @(negedge clk);
      chk("R11", {5'b0, bus_pullup}, 6'b0);
      wcyc(3);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule